// File: doc/BRIEF.md
# UART Interrupt Identity Prioritiser

This block sits beside the FIFOs and serial engines of a FIFO-equipped UART. It collects every condition that can raise an interrupt: a receive line error, the receive fill level reaching a programmable trigger, a character timeout, the transmit fill level falling to a programmable threshold, a modem line change and a busy-detect event. From these it reports the one source with the highest priority as a 4-bit identity code. The code sits inside an 8-bit identity byte, and an interrupt line is driven alongside it.

Software reads the identity byte to find out why the interrupt line rose. When a read returns the transmit-empty code, that source is acknowledged. It stays quiet until the transmit condition goes away and then comes back. The identity byte also tells software whether the FIFOs are switched on. The FIFOs themselves are outside this block. Only their fill counts arrive here.

Top module: `uart_iid_prio`

## Requirements
- R1: After reset the identity byte is 0x01 (code 0001, no interrupt) and `irq` is low.
- R2: Codes are 0110 line status, 0100 receive data, 1100 character timeout, 0010 transmit empty, 0111 busy, 0000 modem, 0001 none. When several sources are pending, the one reported is chosen in this order: line status, receive data, timeout, transmit empty, busy, modem.
- R3: A line error is pending only while `int_en[2]` is 1.
- R4: Receive data is pending while `int_en[0]` is 1 and the receive count is at or above the trigger. With the FIFOs on, `rx_trig_sel` picks the trigger: 0 gives 1, 1 gives DEPTH/4, 2 gives DEPTH/2, 3 gives DEPTH-2. With the FIFOs off the trigger is 1.
- R5: A character timeout is pending only while `int_en[0]` is 1 and the FIFOs are on.
- R6: The transmit-empty condition holds while `int_en[1]` is 1 and the transmit count is at or below the threshold. With the FIFOs on, `tx_trig_sel` picks the threshold: 0 gives 0, 1 gives 2, 2 gives DEPTH/4, 3 gives DEPTH/2. With the FIFOs off the threshold is 0.
- R7: When `iid_rd` is high while the byte shows 0010, the transmit-empty source is cleared. It stays cleared until its condition goes false and then true again. A read that returns any other code leaves the source alone.
- R8: Busy detect (0111) needs no enable bit and ranks above modem status.
- R9: A modem change reports 0000 only while `int_en[3]` is 1.
- R10: Bits 7:6 of the identity byte both equal the FIFO-enabled flag, and bits 5:4 are zero.
- R11: `irq` is high exactly when the reported code is not 0001.
- R12: The identity byte and `irq` follow the inputs one clock edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| int_en | input | 4 | Enables: bit0 receive data/timeout, bit1 transmit empty, bit2 line status, bit3 modem |
| fifo_on | input | 1 | FIFOs enabled |
| rx_trig_sel | input | 2 | Receive trigger select |
| tx_trig_sel | input | 2 | Transmit-empty threshold select |
| rx_level | input | LVL_W | Receive FIFO fill count |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| line_err | input | 1 | Receive line error present |
| char_tmo | input | 1 | Character timeout present |
| modem_chg | input | 1 | Modem line change present |
| busy_det | input | 1 | Busy-detect event present |
| iid_rd | input | 1 | Identity byte is being read this cycle |
| iid_byte | output | 8 | Identity byte: FIFO flags and code |
| irq | output | 1 | Interrupt request |

## Verification
The bench targets the edges of each trigger and threshold table, one count on either side of every boundary. A wrong comparison would show up as an interrupt one character early or late. It also tests a read while a higher-priority source is shown: a design that cleared transmit-empty on any read would lose that interrupt. It then holds the transmit condition true after an acknowledgement, which exposes a design that re-raises the source at once. Stacked sources expose a wrong ordering of busy against modem status or of timeout against receive data. A timeout with the FIFOs off exposes a missing FIFO-mode gate.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

   typedef enum logic [3:0] {
      IID_MODEM = 4'b0000,
      IID_NONE  = 4'b0001,
      IID_THRE  = 4'b0010,
      IID_RDA   = 4'b0100,
      IID_LINE  = 4'b0110,
      IID_BUSY  = 4'b0111,
      IID_TMO   = 4'b1100
   } iid_code_e;

   // source slots, lowest index has highest priority
   localparam int SRC_LINE  = 0;
   localparam int SRC_RDA   = 1;
   localparam int SRC_TMO   = 2;
   localparam int SRC_THRE  = 3;
   localparam int SRC_BUSY  = 4;
   localparam int SRC_MODEM = 5;
   localparam int NUM_SRC   = 6;

   function automatic iid_code_e src_code(input int idx);
      case (idx)
         SRC_LINE:  return IID_LINE;
         SRC_RDA:   return IID_RDA;
         SRC_TMO:   return IID_TMO;
         SRC_THRE:  return IID_THRE;
         SRC_BUSY:  return IID_BUSY;
         SRC_MODEM: return IID_MODEM;
         default:   return IID_NONE;
      endcase
   endfunction

   function automatic int rx_trig_level(input int sel, input int depth);
      case (sel)
         0:       return 1;
         1:       return depth / 4;
         2:       return depth / 2;
         default: return depth - 2;
      endcase
   endfunction

   function automatic int tx_trig_level(input int sel, input int depth);
      case (sel)
         0:       return 0;
         1:       return 2;
         2:       return depth / 4;
         default: return depth / 2;
      endcase
   endfunction

endpackage

// File: rtl/uart_iid_rx_trig.sv
module uart_iid_rx_trig
   import uart_iid_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             fifo_on,
   input  logic [1:0]       sel,
   input  logic [LVL_W-1:0] level,
   output logic             at_trig
);

   logic [LVL_W-1:0] lvl_tab [4];

   for (genvar g = 0; g < 4; g++) begin : g_lvl
      assign lvl_tab[g] = LVL_W'(rx_trig_level(g, DEPTH));
   end

   always_comb begin
      if (fifo_on) at_trig = (level >= lvl_tab[sel]);
      else         at_trig = (level != '0);
   end

endmodule

// File: rtl/uart_iid_tx_empty.sv
module uart_iid_tx_empty
   import uart_iid_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int LVL_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             fifo_on,
   input  logic [1:0]       sel,
   input  logic [LVL_W-1:0] level,
   input  logic             ack,
   output logic             pend
);

   logic [LVL_W-1:0] lvl_tab [4];
   logic             cond;
   logic             acked_q;

   for (genvar g = 0; g < 4; g++) begin : g_lvl
      assign lvl_tab[g] = LVL_W'(tx_trig_level(g, DEPTH));
   end

   always_comb begin
      if (fifo_on) cond = enable && (level <= lvl_tab[sel]);
      else         cond = enable && (level == '0);
   end

   assign pend = cond && !acked_q && !ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      acked_q <= 1'b0;
      else if (!cond)  acked_q <= 1'b0;
      else if (ack)    acked_q <= 1'b1;
   end

   // an acknowledged source stays silent while its condition holds
   AST_ACK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && cond) |=> (!pend || !cond || !$past(cond)) || !acked_q); // R7

endmodule

// File: rtl/uart_iid_enc.sv
module uart_iid_enc
   import uart_iid_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic [N-1:0] pend,
   output logic [N-1:0] grant,
   output iid_code_e    code
);

   always_comb begin
      grant = '0;
      code  = IID_NONE;
      for (int i = N - 1; i >= 0; i--) begin
         if (pend[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            code     = src_code(i);
         end
      end
   end

endmodule

// File: rtl/uart_iid_prio.sv
module uart_iid_prio
   import uart_iid_pkg::*;
#(
   parameter int FIFO_DEPTH = 16,
   parameter int LVL_W      = $clog2(FIFO_DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [3:0]       int_en,
   input  logic             fifo_on,
   input  logic [1:0]       rx_trig_sel,
   input  logic [1:0]       tx_trig_sel,
   input  logic [LVL_W-1:0] rx_level,
   input  logic [LVL_W-1:0] tx_level,
   input  logic             line_err,
   input  logic             char_tmo,
   input  logic             modem_chg,
   input  logic             busy_det,
   input  logic             iid_rd,
   output logic [7:0]       iid_byte,
   output logic             irq
);

   localparam int EN_RDA   = 0;
   localparam int EN_THRE  = 1;
   localparam int EN_LINE  = 2;
   localparam int EN_MODEM = 3;

   if (FIFO_DEPTH < 8 || (FIFO_DEPTH & (FIFO_DEPTH - 1)) != 0) begin : g_bad_depth
      $error("FIFO_DEPTH must be a power of two, at least 8");
   end
   if (LVL_W < $clog2(FIFO_DEPTH + 1)) begin : g_bad_lvl_w
      $error("LVL_W too narrow for FIFO_DEPTH");
   end

   logic [NUM_SRC-1:0] pend;
   logic [NUM_SRC-1:0] grant;
   iid_code_e          win_code;
   iid_code_e          code_q;
   logic               fen_q;
   logic               irq_q;
   logic               rx_hit;
   logic               thre_pend;
   logic               thre_ack;

   assign thre_ack = iid_rd && (code_q == IID_THRE);

   uart_iid_rx_trig #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_rx_trig (
      .fifo_on (fifo_on),
      .sel     (rx_trig_sel),
      .level   (rx_level),
      .at_trig (rx_hit)
   );

   uart_iid_tx_empty #(.DEPTH(FIFO_DEPTH), .LVL_W(LVL_W)) i_tx_empty (
      .clk     (clk),
      .rst_n   (rst_n),
      .enable  (int_en[EN_THRE]),
      .fifo_on (fifo_on),
      .sel     (tx_trig_sel),
      .level   (tx_level),
      .ack     (thre_ack),
      .pend    (thre_pend)
   );

   always_comb begin
      pend            = '0;
      pend[SRC_LINE]  = line_err && int_en[EN_LINE];
      pend[SRC_RDA]   = rx_hit && int_en[EN_RDA];
      pend[SRC_TMO]   = char_tmo && fifo_on && int_en[EN_RDA];
      pend[SRC_THRE]  = thre_pend;
      pend[SRC_BUSY]  = busy_det;
      pend[SRC_MODEM] = modem_chg && int_en[EN_MODEM];
   end

   uart_iid_enc #(.N(NUM_SRC)) i_enc (
      .pend  (pend),
      .grant (grant),
      .code  (win_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code_q <= IID_NONE;
         fen_q  <= 1'b0;
         irq_q  <= 1'b0;
      end else begin
         code_q <= win_code;
         fen_q  <= fifo_on;
         irq_q  <= |pend;
      end
   end

   assign iid_byte = {fen_q, fen_q, 2'b00, code_q};
   assign irq      = irq_q;

   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant)); // R2
   AST_QUIET_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      (int_en == 4'b0000 && !busy_det) |=> code_q == IID_NONE); // R2
   AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (line_err && int_en[EN_LINE]) |=> code_q == IID_LINE); // R3
   AST_THRE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_rd && code_q == IID_THRE) |=> code_q != IID_THRE); // R7
   AST_BUSY_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy_det |=> (code_q != IID_MODEM && code_q != IID_NONE)); // R8
   AST_FIFO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (iid_byte[7:6] == {2{$past(fifo_on)}} && iid_byte[5:4] == 2'b00)); // R10
   AST_IRQ_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (code_q != IID_NONE)); // R11

endmodule

// File: tb/test_uart_iid_prio.sv
module test_uart_iid_prio;

   localparam int DEPTH = 16;
   localparam int LW    = $clog2(DEPTH + 1);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [3:0]    int_en = '0;
   logic          fifo_on = 1'b0;
   logic [1:0]    rx_trig_sel = '0;
   logic [1:0]    tx_trig_sel = '0;
   logic [LW-1:0] rx_level = '0;
   logic [LW-1:0] tx_level = '0;
   logic          line_err = 1'b0;
   logic          char_tmo = 1'b0;
   logic          modem_chg = 1'b0;
   logic          busy_det = 1'b0;
   logic          iid_rd = 1'b0;
   logic [7:0]    iid_byte;
   logic          irq;

   int checks = 0;
   int errors = 0;
   logic [3:0] m_code = 4'b0001;
   logic       m_fen = 1'b0;
   logic       m_acked = 1'b0;

   always #2.5 clk = ~clk;

   uart_iid_prio #(.FIFO_DEPTH(DEPTH)) i_uart_iid_prio (
      .clk(clk), .rst_n(rst_n), .int_en(int_en), .fifo_on(fifo_on),
      .rx_trig_sel(rx_trig_sel), .tx_trig_sel(tx_trig_sel),
      .rx_level(rx_level), .tx_level(tx_level), .line_err(line_err),
      .char_tmo(char_tmo), .modem_chg(modem_chg), .busy_det(busy_det),
      .iid_rd(iid_rd), .iid_byte(iid_byte), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   function automatic int rx_lvl();
      if (!fifo_on) return 1;
      case (rx_trig_sel)
         2'd0: return 1;
         2'd1: return DEPTH / 4;
         2'd2: return DEPTH / 2;
         default: return DEPTH - 2;
      endcase
   endfunction

   function automatic int tx_lvl();
      if (!fifo_on) return 0;
      case (tx_trig_sel)
         2'd0: return 0;
         2'd1: return 2;
         2'd2: return DEPTH / 4;
         default: return DEPTH / 2;
      endcase
   endfunction

   // one clock: model the next code from current inputs, then compare
   task automatic step();
      logic cond, ack, thre;
      logic [3:0] nxt;
      cond = int_en[1] && (int'(tx_level) <= tx_lvl());
      ack  = iid_rd && (m_code == 4'b0010);
      thre = cond && !m_acked && !ack;
      if (line_err && int_en[2])                          nxt = 4'b0110;
      else if (int_en[0] && int'(rx_level) >= rx_lvl())   nxt = 4'b0100;
      else if (int_en[0] && fifo_on && char_tmo)          nxt = 4'b1100;
      else if (thre)                                      nxt = 4'b0010;
      else if (busy_det)                                  nxt = 4'b0111;
      else if (modem_chg && int_en[3])                    nxt = 4'b0000;
      else                                                nxt = 4'b0001;
      if (!cond)    m_acked = 1'b0;
      else if (ack) m_acked = 1'b1;
      m_fen = fifo_on;
      @(posedge clk);
      @(negedge clk);
      m_code = nxt;
      chk("R2 model", iid_byte, {m_fen, m_fen, 2'b00, m_code});
      chk("R11 model", {7'd0, irq}, {7'd0, m_code != 4'b0001});
   endtask

   task automatic idle();
      int_en = '0; fifo_on = 0; rx_trig_sel = 0; tx_trig_sel = 0;
      rx_level = '0; tx_level = '0; line_err = 0; char_tmo = 0;
      modem_chg = 0; busy_det = 0; iid_rd = 0;
   endtask

   task automatic expect_after_step(input string tag, input logic [7:0] exp);
      step();
      chk(tag, iid_byte, exp);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R1 reset byte", iid_byte, 8'h01);
      chk("R1 reset irq", {7'd0, irq}, 8'h00);
      rst_n = 1'b1;
      @(negedge clk);
      expect_after_step("R1 idle", 8'h01);

      // R3 line status gate, R12 latency
      line_err = 1;
      expect_after_step("R3 disabled", 8'h01);
      int_en = 4'b0100;
      #1 chk("R12 before edge", iid_byte, 8'h01);
      expect_after_step("R3 enabled", 8'h06);
      chk("R11 irq high", {7'd0, irq}, 8'h01);
      idle();

      // R4 receive triggers
      fifo_on = 1; int_en = 4'b0001; rx_trig_sel = 2; rx_level = 7;
      expect_after_step("R4 half below", 8'hC1);
      rx_level = 8;
      expect_after_step("R4 half at", 8'hC4);
      rx_trig_sel = 3; rx_level = 13;
      expect_after_step("R4 short below", 8'hC1);
      rx_level = 14;
      expect_after_step("R4 short at", 8'hC4);
      rx_trig_sel = 1; rx_level = 3;
      expect_after_step("R4 quarter below", 8'hC1);
      rx_trig_sel = 0; rx_level = 1;
      expect_after_step("R4 one char", 8'hC4);
      fifo_on = 0;
      expect_after_step("R4 fifo off held", 8'h04);
      rx_level = 0;
      expect_after_step("R4 fifo off empty", 8'h01);

      // R5 timeout
      fifo_on = 1; char_tmo = 1;
      expect_after_step("R5 timeout", 8'hCC);
      rx_level = 1;
      expect_after_step("R5 rda above timeout", 8'hC4);
      rx_level = 0; fifo_on = 0;
      expect_after_step("R5 fifo off", 8'h01);
      idle();

      // R6 transmit thresholds
      fifo_on = 1; int_en = 4'b0010; tx_trig_sel = 1; tx_level = 3;
      expect_after_step("R6 above two", 8'hC1);
      tx_level = 2;
      expect_after_step("R6 at two", 8'hC2);
      tx_trig_sel = 3; tx_level = 8;
      expect_after_step("R6 at half", 8'hC2);
      fifo_on = 0; tx_level = 1;
      expect_after_step("R6 fifo off not empty", 8'h01);
      tx_level = 0;
      expect_after_step("R6 fifo off empty", 8'h02);

      // R7 acknowledge by read
      iid_rd = 1;
      expect_after_step("R7 read clears", 8'h01);
      iid_rd = 0;
      expect_after_step("R7 stays cleared", 8'h01);
      tx_level = 1;
      expect_after_step("R7 condition drops", 8'h01);
      tx_level = 0;
      expect_after_step("R7 re-armed", 8'h02);
      line_err = 1; int_en = 4'b0110;
      expect_after_step("R7 line over thre", 8'h06);
      iid_rd = 1;
      expect_after_step("R7 other read", 8'h06);
      iid_rd = 0; line_err = 0;
      expect_after_step("R7 thre kept", 8'h02);
      idle();

      // R8 / R9 busy and modem
      busy_det = 1; modem_chg = 1; int_en = 4'b1000;
      expect_after_step("R8 busy over modem", 8'h07);
      busy_det = 0;
      expect_after_step("R9 modem enabled", 8'h00);
      chk("R11 irq modem", {7'd0, irq}, 8'h01);
      int_en = 4'b0000;
      expect_after_step("R9 modem disabled", 8'h01);
      busy_det = 1;
      expect_after_step("R8 no enable needed", 8'h07);
      idle();

      // R2 full stack, R10 flags
      fifo_on = 1; int_en = 4'b1111; line_err = 1; rx_level = 16;
      busy_det = 1; modem_chg = 1; char_tmo = 1;
      expect_after_step("R2 stacked", 8'hC6);
      idle();
      fifo_on = 1;
      expect_after_step("R10 fifo flags", 8'hC1);
      idle();

      // constrained random
      for (int n = 0; n < 3000; n++) begin
         if ($urandom_range(7) == 0) fifo_on = 1'($urandom);
         int_en      = 4'($urandom);
         rx_trig_sel = 2'($urandom);
         tx_trig_sel = 2'($urandom);
         rx_level    = LW'($urandom_range(DEPTH));
         tx_level    = LW'($urandom_range(DEPTH));
         line_err    = ($urandom_range(7) == 0);
         char_tmo    = ($urandom_range(3) == 0);
         modem_chg   = ($urandom_range(2) == 0);
         busy_det    = ($urandom_range(7) == 0);
         iid_rd      = ($urandom_range(2) == 0);
         step();
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule